// File: doc/BRIEF.md
# Flash Boot-Region Address Remapper

This block sits between a processor's local-bus request path and a flash array. It turns each request address into a physical flash address, for either of two chip selects. The boot chip select covers a 16 MB window at the top of the array. Inside that window, four static jumper inputs rotate which 512 KB boot image a given offset reaches. A request from the second core can also be moved down by 8 MB when the alternate-boot control bit is set. The user chip select passes the low 27 address bits through unchanged and ignores the jumpers. It addresses the topmost 128 MB page, or a page chosen by software when paging is on. So the top 8 MB of user space always aliases the boot area at its true physical place.

Every translated write is checked against a 256 KB factory recovery area at the base of the boot area. A write that lands there is dropped: the block raises a one-cycle error pulse and no write strobe. A small control register holds the alternate-boot bit, the page enable and the page number. It is reached through a plain write-enable register port.

A small state machine sequences each request. It has four states:
- **IDLE**: ready for a request.
- **READ**: one-cycle read strobe.
- **WRITE**: one-cycle write strobe.
- **REJECT**: one-cycle error pulse.

An accepted request moves the machine to one of these:
- **accept_read**: IDLE to READ.
- **accept_write**: IDLE to WRITE, for a write outside the recovery area.
- **reject_write**: IDLE to REJECT, for a write inside it.

Each of READ, WRITE and REJECT returns to IDLE on the next cycle (**retire**).

Top module: `flash_boot_remap`

## Requirements
- R1: After reset, the control register reads 0 at offset 0x44, `req_ready` is 1, and `fl_rd_stb`, `fl_wr_stb` and `wr_err` are 0.
- R2: A register write at offset 0x44 stores `reg_wdata[3:0]`. The fields are: bit 0 alternate boot, bit 1 page enable, bits 3:2 page number. A read at 0x44 returns these bits with bits 31:4 as zero. A read at any other offset returns 0, and a write at any other offset leaves the register unchanged.
- R3: On the boot chip select (`req_cs`=0), let w = `req_addr[23:0]` and idx = (w[22:19] + `jumper_i`) mod 16. The physical address is 0x1F00_0000 + {w[23], idx, w[18:0]}. A jumper code of 0 leaves the address unchanged, so the reset vector 0xFFF0_0100 reaches 0x1FF0_0100.
- R4: A boot request with `req_core`=1 while the alternate bit is 1 reaches the R3 address minus 0x80_0000. Core 0, or core 1 with the bit at 0, reaches the R3 address.
- R5: On the user chip select (`req_cs`=1), with the page enable at 0, the physical address is {2'b11, `req_addr[26:0]`}, whatever the jumpers. User address 0xEFF0_0000 therefore reaches the same location as boot address 0xFFF0_0000 with a jumper code of 0.
- R6: On the user chip select with the page enable at 1, the physical address is {page number, `req_addr[26:0]`}.
- R7: A write whose physical address lies in 0x1F80_0000..0x1F83_FFFF gives `wr_err` high for one cycle and no `fl_wr_stb`, on either chip select. Reads there, and writes at 0x1F84_0000 and above, proceed normally.
- R8: A request is accepted at a clock edge where `req_valid` and `req_ready` are both 1. In the following cycle exactly one of the following is high: `fl_rd_stb` (read), `fl_wr_stb` (write) or `wr_err` (rejected write). `fl_addr` carries the translated address during a strobe, `req_ready` is 0 in that cycle, and it returns to 1 in the cycle after.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| jumper_i | input | 4 | Static boot-image rotation code |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_cs | input | 1 | 0 boot chip select, 1 user chip select |
| req_core | input | 1 | Issuing core (0 or 1) |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 32 | Local-bus address |
| fl_rd_stb | output | 1 | One-cycle flash read strobe |
| fl_wr_stb | output | 1 | One-cycle flash write strobe |
| fl_addr | output | 29 | Physical flash address |
| wr_err | output | 1 | One-cycle rejected-write pulse |
| reg_we | input | 1 | Control register write enable |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |

## Verification
The hardest case to reach is a boot chip-select write that lands in the recovery area. This happens only when the jumper rotation maps an offset onto image index 0 in the upper half of the window. A random 24-bit offset hits that 256 KB slot about once in 64 tries, and only for one image field per jumper code. The random stimulus therefore biases part of its boot writes. For those, it computes the image field as the negative of the current jumper code and clears bit 18. The directed cases also probe the first byte past the area, and the same area through a user-page write.

// File: rtl/flash_remap_pkg.sv
package flash_remap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_READ   = 2'd1,
        ST_WRITE  = 2'd2,
        ST_REJECT = 2'd3
    } fr_state_e;

    typedef enum logic {
        CS_BOOT = 1'b0,
        CS_USER = 1'b1
    } fr_cs_e;

    // packed MSB first: page[3:2], page_en[1], alt_boot[0]
    typedef struct packed {
        logic [1:0] page;
        logic       page_en;
        logic       alt_boot;
    } fr_ctrl_t;

    localparam int CTRL_W = $bits(fr_ctrl_t);

endpackage

// File: rtl/fr_ctrl_reg.sv
module fr_ctrl_reg
    import flash_remap_pkg::*;
#(
    parameter int            REG_AW   = 8,
    parameter int            DATA_W   = 32,
    parameter logic [REG_AW-1:0] CTRL_OFS = 8'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output fr_ctrl_t          ctrl
);

    localparam int PAD_W = DATA_W - CTRL_W;

    logic     hit;
    fr_ctrl_t ctrl_q;
    logic     unused_wdata;

    assign hit          = (addr == CTRL_OFS);
    assign unused_wdata = ^wdata[DATA_W-1:CTRL_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (we && hit) begin
            ctrl_q <= fr_ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata = {{PAD_W{1'b0}}, ctrl_q};
        end
    end

    assign ctrl = ctrl_q;

endmodule

// File: rtl/fr_boot_map.sv
module fr_boot_map #(
    parameter int FLASH_AW = 29,
    parameter int WIN_BITS = 24,
    parameter int IMG_BITS = 4
) (
    input  logic [WIN_BITS-1:0] win_addr,
    input  logic [IMG_BITS-1:0] rot,
    input  logic                alt_sel,
    output logic [FLASH_AW-1:0] phys
);

    localparam int HALF   = WIN_BITS - 1;
    localparam int IMG_LO = HALF - IMG_BITS;
    localparam logic [FLASH_AW-1:0] WIN_BASE = {FLASH_AW{1'b1}} << WIN_BITS;
    localparam logic [FLASH_AW-1:0] ALT_OFS  = FLASH_AW'(1) << HALF;

    logic [IMG_BITS-1:0] img;
    logic [WIN_BITS-1:0] rot_addr;
    logic [FLASH_AW-1:0] base_phys;

    always_comb begin
        img       = win_addr[HALF-1:IMG_LO] + rot;
        rot_addr  = {win_addr[WIN_BITS-1], img, win_addr[IMG_LO-1:0]};
        base_phys = WIN_BASE + FLASH_AW'(rot_addr);
        phys      = alt_sel ? (base_phys - ALT_OFS) : base_phys;
    end

endmodule

// File: rtl/fr_user_map.sv
module fr_user_map #(
    parameter int FLASH_AW  = 29,
    parameter int PAGE_BITS = 27
) (
    input  logic [PAGE_BITS-1:0] page_addr,
    input  logic                 page_en,
    input  logic [1:0]           page_sel,
    output logic [FLASH_AW-1:0]  phys
);

    generate
        if (FLASH_AW > PAGE_BITS) begin : g_paged
            localparam int PG_W = FLASH_AW - PAGE_BITS;
            logic [PG_W-1:0] pg;
            always_comb begin
                pg   = page_en ? PG_W'(page_sel) : {PG_W{1'b1}};
                phys = {pg, page_addr};
            end
        end else begin : g_flat
            logic unused_page;
            assign unused_page = page_en ^ (^page_sel);
            assign phys        = page_addr[FLASH_AW-1:0];
        end
    endgenerate

endmodule

// File: rtl/fr_guard.sv
module fr_guard #(
    parameter int FLASH_AW  = 29,
    parameter int BOOT_BITS = 23,
    parameter int REC_BITS  = 18
) (
    input  logic [FLASH_AW-1:0] phys,
    output logic                in_recovery
);

    localparam logic [FLASH_AW-1:0] REC_BASE = {FLASH_AW{1'b1}} << BOOT_BITS;
    localparam int                  TAG_W    = FLASH_AW - REC_BITS;

    logic [TAG_W-1:0] tag;
    logic [TAG_W-1:0] rec_tag;

    assign tag         = phys[FLASH_AW-1:REC_BITS];
    assign rec_tag     = REC_BASE[FLASH_AW-1:REC_BITS];
    assign in_recovery = (tag == rec_tag);

endmodule

// File: rtl/flash_boot_remap.sv
module flash_boot_remap
    import flash_remap_pkg::*;
#(
    parameter int FLASH_AW  = 29,
    parameter int BUS_AW    = 32,
    parameter int WIN_BITS  = 24,
    parameter int IMG_BITS  = 4,
    parameter int PAGE_BITS = 27,
    parameter int REC_BITS  = 18,
    parameter int REG_AW    = 8,
    parameter int DATA_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IMG_BITS-1:0] jumper_i,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_cs,
    input  logic                req_core,
    input  logic                req_write,
    input  logic [BUS_AW-1:0]   req_addr,
    output logic                fl_rd_stb,
    output logic                fl_wr_stb,
    output logic [FLASH_AW-1:0] fl_addr,
    output logic                wr_err,
    input  logic                reg_we,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata
);

    localparam int BOOT_BITS = WIN_BITS - 1;

    fr_state_e           state_q;
    fr_state_e           state_d;
    fr_ctrl_t            ctrl;
    logic [FLASH_AW-1:0] boot_phys;
    logic [FLASH_AW-1:0] user_phys;
    logic [FLASH_AW-1:0] sel_phys;
    logic [FLASH_AW-1:0] addr_q;
    logic                alt_sel;
    logic                rec_hit;
    logic                accept;
    logic                unused_addr;

    assign unused_addr = ^req_addr[BUS_AW-1:PAGE_BITS];

    fr_ctrl_reg #(
        .REG_AW (REG_AW),
        .DATA_W (DATA_W)
    ) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .ctrl  (ctrl)
    );

    assign alt_sel = req_core & ctrl.alt_boot;

    fr_boot_map #(
        .FLASH_AW (FLASH_AW),
        .WIN_BITS (WIN_BITS),
        .IMG_BITS (IMG_BITS)
    ) u_boot (
        .win_addr (req_addr[WIN_BITS-1:0]),
        .rot      (jumper_i),
        .alt_sel  (alt_sel),
        .phys     (boot_phys)
    );

    fr_user_map #(
        .FLASH_AW  (FLASH_AW),
        .PAGE_BITS (PAGE_BITS)
    ) u_user (
        .page_addr (req_addr[PAGE_BITS-1:0]),
        .page_en   (ctrl.page_en),
        .page_sel  (ctrl.page),
        .phys      (user_phys)
    );

    assign sel_phys = (fr_cs_e'(req_cs) == CS_USER) ? user_phys : boot_phys;

    fr_guard #(
        .FLASH_AW  (FLASH_AW),
        .BOOT_BITS (BOOT_BITS),
        .REC_BITS  (REC_BITS)
    ) u_guard (
        .phys        (sel_phys),
        .in_recovery (rec_hit)
    );

    assign accept = req_valid && (state_q == ST_IDLE);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (!req_write)   state_d = ST_READ;   // accept_read
                    else if (rec_hit) state_d = ST_REJECT; // reject_write
                    else              state_d = ST_WRITE;  // accept_write
                end
            end
            ST_READ:   state_d = ST_IDLE;                  // retire
            ST_WRITE:  state_d = ST_IDLE;                  // retire
            ST_REJECT: state_d = ST_IDLE;                  // retire
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (accept) begin
            addr_q <= sel_phys;
        end
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        fl_rd_stb = 1'b0;
        fl_wr_stb = 1'b0;
        wr_err    = 1'b0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_READ:   fl_rd_stb = 1'b1;
            ST_WRITE:  fl_wr_stb = 1'b1;
            ST_REJECT: wr_err    = 1'b1;
            default:   req_ready = 1'b0;
        endcase
    end

    assign fl_addr = addr_q;

endmodule

// File: rtl/flash_boot_remap_chk.sv
module flash_boot_remap_chk #(
    parameter int FLASH_AW  = 29,
    parameter int BUS_AW    = 32,
    parameter int PAGE_BITS = 27,
    parameter int WIN_BITS  = 24,
    parameter int REC_BITS  = 18,
    parameter int DATA_W    = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic                req_cs,
    input logic [BUS_AW-1:0]   req_addr,
    input logic                req_write,
    input logic                fl_rd_stb,
    input logic                fl_wr_stb,
    input logic [FLASH_AW-1:0] fl_addr,
    input logic                wr_err,
    input logic [DATA_W-1:0]   reg_rdata
);

    localparam logic [FLASH_AW-1:0] REC_LO = {FLASH_AW{1'b1}} << (WIN_BITS - 1);
    localparam logic [FLASH_AW-1:0] REC_HI = REC_LO + (FLASH_AW'(1) << REC_BITS);

    logic busy;
    assign busy = fl_rd_stb | fl_wr_stb | wr_err;

    a_r8_accept_issues: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fl_rd_stb, fl_wr_stb, wr_err}));

    a_r8_not_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

    a_r8_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy && req_ready));

    a_r8_kind_matches: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> fl_rd_stb);

    a_r7_no_recovery_write: assert property (@(posedge clk) disable iff (!rst_n)
        fl_wr_stb |-> !((fl_addr >= REC_LO) && (fl_addr < REC_HI)));

    a_r7_err_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> !wr_err);

    a_r5_user_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_cs && !req_write)
            |=> (fl_addr[PAGE_BITS-1:0] == $past(req_addr[PAGE_BITS-1:0])));

    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[DATA_W-1:4] == '0);

endmodule

bind flash_boot_remap flash_boot_remap_chk #(
    .FLASH_AW  (FLASH_AW),
    .BUS_AW    (BUS_AW),
    .PAGE_BITS (PAGE_BITS),
    .WIN_BITS  (WIN_BITS),
    .REC_BITS  (REC_BITS),
    .DATA_W    (DATA_W)
) u_chk (.*);

// File: tb/flash_boot_remap_bench.sv
module flash_boot_remap_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  jumper_i = 4'd0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_cs = 1'b0;
    logic        req_core = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic        fl_rd_stb;
    logic        fl_wr_stb;
    logic [28:0] fl_addr;
    logic        wr_err;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0] m_ctrl = 4'd0;

    always #2 clk = ~clk;

    flash_boot_remap u_flash_boot_remap (
        .clk(clk), .rst_n(rst_n), .jumper_i(jumper_i),
        .req_valid(req_valid), .req_ready(req_ready), .req_cs(req_cs),
        .req_core(req_core), .req_write(req_write), .req_addr(req_addr),
        .fl_rd_stb(fl_rd_stb), .fl_wr_stb(fl_wr_stb), .fl_addr(fl_addr),
        .wr_err(wr_err), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [28:0] ref_phys(input logic cs, input logic core,
                                             input logic [31:0] a, input logic [3:0] jmp,
                                             input logic [3:0] c);
        logic [23:0] w;
        logic [3:0]  idx;
        logic [28:0] p;
        if (cs) begin
            p = {(c[1] ? c[3:2] : 2'b11), a[26:0]};
        end else begin
            w   = a[23:0];
            idx = w[22:19] + jmp;
            p   = 29'h1F00_0000 + {5'd0, w[23], idx, w[18:0]};
            if (core && c[0]) p = p - 29'h80_0000;
        end
        return p;
    endfunction

    function automatic logic in_rec(input logic [28:0] p);
        return (p >= 29'h1F80_0000) && (p < 29'h1F84_0000);
    endfunction

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a == 8'h44) m_ctrl = d[3:0];
    endtask

    task automatic reg_rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(tag, 64'(reg_rdata), 64'(exp));
    endtask

    task automatic do_req(input string tag, input logic cs, input logic core,
                          input logic wr, input logic [31:0] a);
        logic [28:0] exp;
        logic        rej;
        exp = ref_phys(cs, core, a, jumper_i, m_ctrl);
        rej = wr && in_rec(exp);
        @(negedge clk);
        req_valid = 1'b1; req_cs = cs; req_core = core; req_write = wr; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R8 rd_stb"}, 64'(fl_rd_stb), 64'(!wr));
        chk({tag, " R7 wr_stb"}, 64'(fl_wr_stb), 64'(wr && !rej));
        chk({tag, " R7 wr_err"}, 64'(wr_err), 64'(rej));
        chk({tag, " R8 ready low"}, 64'(req_ready), 64'd0);
        if (!rej) chk({tag, " addr"}, 64'(fl_addr), 64'(exp));
        @(negedge clk);
        chk({tag, " R8 retire"}, 64'({req_ready, fl_rd_stb, fl_wr_stb, wr_err}), 64'h8);
    endtask

    initial begin
        #(4 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        reg_rd("R1 ctrl reset", 8'h44, 32'd0);
        chk("R1 idle outputs", 64'({req_ready, fl_rd_stb, fl_wr_stb, wr_err}), 64'h8);

        // R2 register port
        reg_wr(8'h44, 32'hFFFF_FFF6);
        reg_rd("R2 readback", 8'h44, 32'h6);
        reg_wr(8'h40, 32'h0000_0009);
        reg_rd("R2 other offset ignored", 8'h44, 32'h6);
        reg_rd("R2 other offset reads 0", 8'h40, 32'h0);
        reg_wr(8'h44, 32'h0);

        // R3 reset vector, jumper 0, and a rotated image
        do_req("R3 reset vector", 1'b0, 1'b0, 1'b0, 32'hFFF0_0100);
        chk("R3 reset vector phys", 64'(fl_addr), 64'h1FF0_0100);
        jumper_i = 4'd5;
        do_req("R3 rotated", 1'b0, 1'b0, 1'b0, 32'hFFF0_0100);
        do_req("R3 wrap", 1'b0, 1'b0, 1'b1, 32'hFF7A_BCD0);

        // R4 alternate region for core 1
        reg_wr(8'h44, 32'h1);
        do_req("R4 core1 alt", 1'b0, 1'b1, 1'b0, 32'hFFF0_0100);
        do_req("R4 core0 unaffected", 1'b0, 1'b0, 1'b0, 32'hFFF0_0100);
        reg_wr(8'h44, 32'h0);
        do_req("R4 core1 no alt", 1'b0, 1'b1, 1'b0, 32'hFF12_3456);

        // R5 user mirror independent of jumpers
        jumper_i = 4'd0;
        do_req("R5 boot ref", 1'b0, 1'b0, 1'b0, 32'hFFF0_0000);
        chk("R5 boot ref phys", 64'(fl_addr), 64'h1FF0_0000);
        jumper_i = 4'd9;
        do_req("R5 user mirror", 1'b1, 1'b0, 1'b0, 32'hEFF0_0000);
        chk("R5 mirror phys", 64'(fl_addr), 64'h1FF0_0000);

        // R6 paged user window
        reg_wr(8'h44, 32'h6);
        do_req("R6 page1", 1'b1, 1'b0, 1'b1, 32'hE123_4568);
        chk("R6 page1 phys", 64'(fl_addr), 64'h0923_4568);

        // R7 recovery area
        reg_wr(8'h44, 32'hE);
        do_req("R7 user write rec", 1'b1, 1'b0, 1'b1, 32'hE780_0010);
        do_req("R7 user read rec", 1'b1, 1'b0, 1'b0, 32'hE780_0010);
        do_req("R7 past end", 1'b1, 1'b0, 1'b1, 32'hE784_0000);
        do_req("R7 last byte", 1'b1, 1'b1, 1'b1, 32'hE783_FFFF);
        jumper_i = 4'd3;
        do_req("R7 boot write rec", 1'b0, 1'b0, 1'b1, {8'hFF, 1'b1, 4'd13, 19'h1_2340});

        // random traffic
        for (int i = 0; i < 400; i++) begin
            logic [31:0] a;
            logic        cs;
            if ($urandom_range(0, 9) == 0) reg_wr(8'h44, $urandom);
            if ($urandom_range(0, 7) == 0) begin
                @(negedge clk);
                jumper_i = 4'($urandom);
            end
            cs = 1'($urandom);
            a  = $urandom;
            if (!cs && $urandom_range(0, 3) == 0) begin
                a[23]    = 1'b1;
                a[22:19] = 4'd0 - jumper_i;
                a[18]    = 1'b0;
            end
            do_req("R3 R4 R5 R6 R7 random", cs, 1'($urandom), 1'($urandom), a);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule